// File: doc/BRIEF.md
# Ethernet PHY Link Bring-Up Sequencer

This block drives the management side of an Ethernet PHY through its standard clause-22 register set. It issues single register reads and writes to an MDIO master, which is outside the block. Each access is held until the master returns a one-cycle completion. On a start pulse the block has two paths. On the negotiation path it reads the status register and rebuilds the four speed/duplex advertisement bits from the matching ability bits. It then turns negotiation on, restarts it, and polls the control register until the restart bit clears.

The forced path is taken when the restart bit never clears, or when software asks for a fixed mode at start. On this path the block writes a fixed speed/duplex word to the control register. Unless the PHY is flagged as exempt, it also clears a transmitter-disable bit in a vendor configuration register. On both paths the block then reports which wait state it reached, drops `busy`, and arms a link-check timer of 1.2 s. That time is derived from the clock-frequency parameter and can be shortened by a divider parameter. When the timer runs out, `check_due` pulses once.

Top module: `phy_linkup_seq`

## Requirements
- R1: After reset, `busy`, `mdio_req_valid`, `timeout_flag` and `check_due` are 0 and `link_state` is idle (0).
- R2: The value written to the advertisement register (address 4) equals the value read from it, with bits 5, 6, 7 and 8 replaced by status register (address 1) bits 11, 12, 13 and 14 respectively.
- R3: Status bit 15 (T4 ability) has no effect on the advertisement write, and advertisement bit 9 is passed through as read.
- R4: On the negotiation path the control register (address 0) is written twice in order: first 0x1000 (enable bit 12), then 0x1200 (enable plus restart bit 9).
- R5: The control register is then read repeatedly, with a constant spacing of POLL_CYCLES (CLK_HZ/100000) idle cycles plus the access time. The first read with bit 9 clear ends the polling with `link_state` = 1 (arbitration wait) and `timeout_flag` = 0.
- R6: If 63 consecutive polls all return bit 9 set, no further poll is made, `timeout_flag` becomes 1, and the control register is written with 0x2000 (speed bit 13 only).
- R7: With `force_req` = 1 at start, negotiation is skipped. The control register is written once with 0x2000 when `force_aneg` = 1, otherwise with bit 13 = `force_speed100` and bit 8 = `force_full`.
- R8: On the forced path with `phy_exempt` = 0, the vendor register (address VCFG_ADDR, default 0x18) is read and written back with bit VCFG_DIS_BIT (default 5) cleared. With `phy_exempt` = 1 it is not accessed. The path ends with `link_state` = 2 (link-try wait).
- R9: When the last access completes, `busy` falls in the same cycle, and `check_due` pulses for exactly one cycle WAIT_CYCLES cycles later (CLK_HZ·1.2/WAIT_DIV).
- R10: `start` is ignored while `busy` is 1: no access is repeated and no extra access is made.
- R11: `start` while not busy restarts the sequence, including in the cycle `check_due` is high. It clears `timeout_flag` and returns `link_state` to idle until the new path ends.
- R12: A request holds its address, direction and write data stable until `mdio_rsp_done`. No request is made while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (accepted when not busy) |
| force_req | input | 1 | Skip negotiation and use a fixed mode |
| force_aneg | input | 1 | With force_req, use the default fixed word 0x2000 |
| force_speed100 | input | 1 | Fixed mode speed: 1 = 100 Mb/s |
| force_full | input | 1 | Fixed mode duplex: 1 = full |
| phy_exempt | input | 1 | PHY needs no transmitter-disable clearing |
| mdio_req_valid | output | 1 | Register access request |
| mdio_req_write | output | 1 | 1 = write, 0 = read |
| mdio_req_addr | output | 5 | PHY register address |
| mdio_req_wdata | output | 16 | Write data |
| mdio_rsp_done | input | 1 | One-cycle completion of the current access |
| mdio_rsp_rdata | input | 16 | Read data, valid with mdio_rsp_done |
| busy | output | 1 | Register accesses in progress |
| link_state | output | 2 | 0 idle, 1 arbitration wait, 2 link-try wait |
| timeout_flag | output | 1 | Restart bit never cleared; forced fallback taken |
| check_due | output | 1 | One-cycle pulse when the link-check wait expires |

## Verification
The wait-timer expiry and a fresh start request can land in the same cycle. If they do, the restart must win: no stale hold state, and `busy` must rise on the next cycle with `link_state` back at idle. The bench counts cycles from the fall of `busy` until the cycle `check_due` is first seen, and raises `start` in exactly that cycle. It then judges the outcome one cycle later at the ports. A second collision is a start pulse arriving in the middle of a running sequence. This is judged by the per-register write counts the responder logs.

// File: rtl/linkup_pkg.sv
package linkup_pkg;
  localparam int DW = 16;
  localparam int AW = 5;

  localparam logic [AW-1:0] ADDR_CTRL = 5'd0;
  localparam logic [AW-1:0] ADDR_STAT = 5'd1;
  localparam logic [AW-1:0] ADDR_ADV  = 5'd4;

  localparam int CTRL_SPEED100 = 13;
  localparam int CTRL_AN_EN    = 12;
  localparam int CTRL_AN_RST   = 9;
  localparam int CTRL_FULL     = 8;

  localparam int N_ABIL        = 4;
  localparam int STAT_ABIL_LSB = 11;
  localparam int ADV_ABIL_LSB  = 5;

  typedef enum logic [1:0] {
    LS_IDLE     = 2'd0,
    LS_ARBWAIT  = 2'd1,
    LS_LTRYWAIT = 2'd2
  } lstate_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_STAT, S_RD_ADV, S_WR_ADV, S_WR_ANEN, S_WR_ANRS,
    S_POLL_RD, S_POLL_GAP, S_WR_FORCE, S_RD_VCFG, S_WR_VCFG,
    S_WAIT, S_HOLD
  } seq_e;

  typedef struct packed {
    logic req;
    logic aneg;
    logic spd100;
    logic full;
    logic exempt;
  } force_cfg_t;
endpackage

// File: rtl/linkup_adv_merge.sv
module linkup_adv_merge #(
  parameter int W        = 16,
  parameter int N        = 4,
  parameter int STAT_LSB = 11,
  parameter int ADV_LSB  = 5
) (
  input  logic [W-1:0] stat,
  input  logic [W-1:0] adv_in,
  output logic [W-1:0] adv_out
);
  localparam int ADV_MSB = ADV_LSB + N - 1;

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g >= ADV_LSB && g <= ADV_MSB) begin : g_abil
      assign adv_out[g] = stat[STAT_LSB + g - ADV_LSB];
    end else begin : g_keep
      assign adv_out[g] = adv_in[g];
    end
  end
endmodule

// File: rtl/linkup_timer.sv
module linkup_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= load ? load_val : cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
  import linkup_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 125_000_000,
  parameter int unsigned WAIT_DIV     = 1,
  parameter int unsigned MAX_POLLS    = 63,
  parameter logic [4:0]  VCFG_ADDR    = 5'h18,
  parameter int unsigned VCFG_DIS_BIT = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        force_req,
  input  logic        force_aneg,
  input  logic        force_speed100,
  input  logic        force_full,
  input  logic        phy_exempt,
  output logic        mdio_req_valid,
  output logic        mdio_req_write,
  output logic [4:0]  mdio_req_addr,
  output logic [15:0] mdio_req_wdata,
  input  logic        mdio_rsp_done,
  input  logic [15:0] mdio_rsp_rdata,
  output logic        busy,
  output logic [1:0]  link_state,
  output logic        timeout_flag,
  output logic        check_due
);
  localparam int unsigned POLL_RAW    = CLK_HZ / 100_000;
  localparam int unsigned POLL_CYCLES = (POLL_RAW > 0) ? POLL_RAW : 1;
  localparam longint unsigned WAIT_RAW =
    (longint'(CLK_HZ) * 12) / (10 * longint'(WAIT_DIV));
  localparam int unsigned WAIT_CYCLES = (WAIT_RAW > 0) ? int'(WAIT_RAW) : 1;
  localparam int unsigned TMAX = (WAIT_CYCLES > POLL_CYCLES) ? WAIT_CYCLES : POLL_CYCLES;
  localparam int TW  = $clog2(TMAX + 1);
  localparam int PCW = $clog2(MAX_POLLS + 1);

  seq_e          state_q, state_d;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;
  logic [PCW-1:0] poll_q, poll_d;
  force_cfg_t    fcfg_q, fcfg_d;
  lstate_e       ls_q, ls_d;
  logic          tflag_q, tflag_d;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic [DW-1:0] adv_merged;
  logic [DW-1:0] force_word;
  logic          idle_like;

  linkup_adv_merge #(
    .W(DW), .N(N_ABIL), .STAT_LSB(STAT_ABIL_LSB), .ADV_LSB(ADV_ABIL_LSB)
  ) u_merge (
    .stat    (data_q),
    .adv_in  (mdio_rsp_rdata),
    .adv_out (adv_merged)
  );

  linkup_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // Fixed-mode control word
  always_comb begin
    force_word = '0;
    if (fcfg_q.req && !fcfg_q.aneg) begin
      force_word[CTRL_SPEED100] = fcfg_q.spd100;
      force_word[CTRL_FULL]     = fcfg_q.full;
    end else begin
      force_word[CTRL_SPEED100] = 1'b1;
    end
  end

  assign idle_like = (state_q == S_IDLE) || (state_q == S_WAIT) || (state_q == S_HOLD);

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    data_d   = data_q;
    data_en  = 1'b0;
    poll_d   = poll_q;
    fcfg_d   = fcfg_q;
    ls_d     = ls_q;
    tflag_d  = tflag_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(WAIT_CYCLES);
    unique case (state_q)
      S_IDLE, S_WAIT, S_HOLD: begin
        if (start) begin
          state_d = force_req ? S_WR_FORCE : S_RD_STAT;
          fcfg_d  = '{req: force_req, aneg: force_aneg, spd100: force_speed100,
                      full: force_full, exempt: phy_exempt};
          ls_d    = LS_IDLE;
          tflag_d = 1'b0;
          poll_d  = '0;
        end else if (state_q == S_WAIT && tmr_zero) begin
          state_d = S_HOLD;
        end
      end
      S_RD_STAT: if (mdio_rsp_done) begin
        data_d  = mdio_rsp_rdata;
        data_en = 1'b1;
        state_d = S_RD_ADV;
      end
      S_RD_ADV: if (mdio_rsp_done) begin
        data_d  = adv_merged;
        data_en = 1'b1;
        state_d = S_WR_ADV;
      end
      S_WR_ADV:  if (mdio_rsp_done) state_d = S_WR_ANEN;
      S_WR_ANEN: if (mdio_rsp_done) state_d = S_WR_ANRS;
      S_WR_ANRS: if (mdio_rsp_done) state_d = S_POLL_RD;
      S_POLL_RD: if (mdio_rsp_done) begin
        if (!mdio_rsp_rdata[CTRL_AN_RST]) begin
          state_d  = S_WAIT;
          ls_d     = LS_ARBWAIT;
          tmr_load = 1'b1;
        end else if (poll_q == PCW'(MAX_POLLS - 1)) begin
          state_d = S_WR_FORCE;
          tflag_d = 1'b1;
        end else begin
          poll_d   = poll_q + 1'b1;
          state_d  = S_POLL_GAP;
          tmr_load = 1'b1;
          tmr_val  = TW'(POLL_CYCLES);
        end
      end
      S_POLL_GAP: if (tmr_zero) state_d = S_POLL_RD;
      S_WR_FORCE: if (mdio_rsp_done) begin
        if (fcfg_q.exempt) begin
          state_d  = S_WAIT;
          ls_d     = LS_LTRYWAIT;
          tmr_load = 1'b1;
        end else begin
          state_d = S_RD_VCFG;
        end
      end
      S_RD_VCFG: if (mdio_rsp_done) begin
        data_d               = mdio_rsp_rdata;
        data_d[VCFG_DIS_BIT] = 1'b0;
        data_en              = 1'b1;
        state_d              = S_WR_VCFG;
      end
      S_WR_VCFG: if (mdio_rsp_done) begin
        state_d  = S_WAIT;
        ls_d     = LS_LTRYWAIT;
        tmr_load = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      data_q  <= '0;
      poll_q  <= '0;
      fcfg_q  <= '0;
      ls_q    <= LS_IDLE;
      tflag_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (data_en) data_q <= data_d;
      poll_q  <= poll_d;
      fcfg_q  <= fcfg_d;
      ls_q    <= ls_d;
      tflag_q <= tflag_d;
    end
  end

  // Request decode
  always_comb begin
    mdio_req_valid = 1'b1;
    mdio_req_write = 1'b0;
    mdio_req_addr  = ADDR_CTRL;
    mdio_req_wdata = '0;
    unique case (state_q)
      S_RD_STAT: mdio_req_addr = ADDR_STAT;
      S_RD_ADV:  mdio_req_addr = ADDR_ADV;
      S_WR_ADV: begin
        mdio_req_write = 1'b1;
        mdio_req_addr  = ADDR_ADV;
        mdio_req_wdata = data_q;
      end
      S_WR_ANEN: begin
        mdio_req_write             = 1'b1;
        mdio_req_wdata[CTRL_AN_EN] = 1'b1;
      end
      S_WR_ANRS: begin
        mdio_req_write              = 1'b1;
        mdio_req_wdata[CTRL_AN_EN]  = 1'b1;
        mdio_req_wdata[CTRL_AN_RST] = 1'b1;
      end
      S_POLL_RD: mdio_req_addr = ADDR_CTRL;
      S_WR_FORCE: begin
        mdio_req_write = 1'b1;
        mdio_req_wdata = force_word;
      end
      S_RD_VCFG: mdio_req_addr = VCFG_ADDR;
      S_WR_VCFG: begin
        mdio_req_write = 1'b1;
        mdio_req_addr  = VCFG_ADDR;
        mdio_req_wdata = data_q;
      end
      default: mdio_req_valid = 1'b0;
    endcase
  end

  assign busy         = !idle_like;
  assign link_state   = ls_q;
  assign timeout_flag = tflag_q;
  assign check_due    = (state_q == S_WAIT) && tmr_zero;
endmodule

// File: rtl/linkup_seq_chk.sv
module linkup_seq_chk #(
  parameter int unsigned MAX_POLLS = 63
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        mdio_req_valid,
  input logic        mdio_req_write,
  input logic [4:0]  mdio_req_addr,
  input logic [15:0] mdio_req_wdata,
  input logic        mdio_rsp_done,
  input logic [1:0]  link_state,
  input logic        timeout_flag,
  input logic        check_due
);
  localparam int CW = $clog2(MAX_POLLS + 2);
  logic [CW-1:0] polls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polls_q <= '0;
    end else if (start && !busy) begin
      polls_q <= '0;
    end else if (busy && mdio_req_valid && !mdio_req_write &&
                 mdio_req_addr == 5'd0 && mdio_rsp_done && polls_q != '1) begin
      polls_q <= polls_q + 1'b1;
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req_valid && !mdio_rsp_done |=> mdio_req_valid && $stable(mdio_req_addr) &&
    $stable(mdio_req_write) && $stable(mdio_req_wdata));

  assert_no_req_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_req_valid);

  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q <= CW'(MAX_POLLS));

  assert_timeout_after_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> polls_q == CW'(MAX_POLLS) && busy);

  assert_due_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    check_due |-> !busy ##1 !check_due);

  assert_state_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_state != 2'd3);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !mdio_rsp_done |=> busy);
endmodule

bind phy_linkup_seq linkup_seq_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .busy           (busy),
  .mdio_req_valid (mdio_req_valid),
  .mdio_req_write (mdio_req_write),
  .mdio_req_addr  (mdio_req_addr),
  .mdio_req_wdata (mdio_req_wdata),
  .mdio_rsp_done  (mdio_rsp_done),
  .link_state     (link_state),
  .timeout_flag   (timeout_flag),
  .check_due      (check_due)
);

// File: tb/test_phy_linkup_seq.sv
module test_phy_linkup_seq;
  localparam int CLK_HZ = 1_000_000;
  localparam int WDIV   = 10_000;
  localparam int POLL   = CLK_HZ / 100_000;       // 10
  localparam int WAITC  = CLK_HZ * 12 / (10 * WDIV); // 120
  localparam int LAT    = 2;
  localparam int GAP    = POLL + LAT + 1;          // poll-to-poll spacing
  localparam int WD_CYC = 150_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, force_req = 1'b0, force_aneg = 1'b0;
  logic force_speed100 = 1'b0, force_full = 1'b0, phy_exempt = 1'b0;
  logic mdio_req_valid, mdio_req_write;
  logic [4:0] mdio_req_addr;
  logic [15:0] mdio_req_wdata;
  logic mdio_rsp_done = 1'b0;
  logic [15:0] mdio_rsp_rdata = '0;
  logic busy, timeout_flag, check_due;
  logic [1:0] link_state;

  always #4 clk = ~clk;

  phy_linkup_seq #(.CLK_HZ(CLK_HZ), .WAIT_DIV(WDIV)) i_phy_linkup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .force_req(force_req),
    .force_aneg(force_aneg), .force_speed100(force_speed100),
    .force_full(force_full), .phy_exempt(phy_exempt),
    .mdio_req_valid(mdio_req_valid), .mdio_req_write(mdio_req_write),
    .mdio_req_addr(mdio_req_addr), .mdio_req_wdata(mdio_req_wdata),
    .mdio_rsp_done(mdio_rsp_done), .mdio_rsp_rdata(mdio_rsp_rdata),
    .busy(busy), .link_state(link_state), .timeout_flag(timeout_flag),
    .check_due(check_due));

  int checks = 0, errors = 0;
  bit finished = 0;

  // PHY register model
  logic [15:0] regs [32];
  int wcount [32];
  int rcount [32];
  logic [15:0] ctrl_log [8];
  int ctrl_n, stick, rst_left, poll_n, gap_bad;
  longint last_poll_t;
  logic ls_at_busy, busy_seen;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int i = 0; i < 32; i++) begin wcount[i] = 0; rcount[i] = 0; end
    for (int i = 0; i < 8; i++) ctrl_log[i] = '0;
    ctrl_n = 0; poll_n = 0; gap_bad = 0; last_poll_t = -1;
  endtask

  // Responder: accepts at negedge, completes LAT-1 negedges later
  initial begin
    forever begin
      @(negedge clk);
      mdio_rsp_done = 1'b0;
      if (mdio_req_valid) begin
        logic [4:0] a;
        a = mdio_req_addr;
        if (mdio_req_write) begin
          regs[a] = mdio_req_wdata;
          wcount[a]++;
          if (a == 5'd0) begin
            if (ctrl_n < 8) ctrl_log[ctrl_n] = mdio_req_wdata;
            ctrl_n++;
            if (mdio_req_wdata[9]) rst_left = stick;
          end
          mdio_rsp_rdata = '0;
        end else begin
          rcount[a]++;
          if (a == 5'd0) begin
            mdio_rsp_rdata = regs[0] & ~16'h0200;
            if (rst_left > 0) begin mdio_rsp_rdata[9] = 1'b1; rst_left--; end
            if (last_poll_t >= 0 && ($time - last_poll_t) / 8 != GAP) gap_bad++;
            last_poll_t = $time;
            poll_n++;
          end else begin
            mdio_rsp_rdata = regs[a];
          end
        end
        repeat (LAT - 1) @(negedge clk);
        mdio_rsp_done = 1'b1;
      end
    end
  end

  task automatic run_seq();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    busy_seen = busy; ls_at_busy = (link_state == 2'd0);
    while (busy) @(negedge clk);
  endtask

  // {status, adv as read, adv expected}
  localparam logic [47:0] ADV_VEC [7] = '{
    {16'h7800, 16'h0001, 16'h01E1},
    {16'h0000, 16'h01E1, 16'h0001},
    {16'h8000, 16'h0201, 16'h0201},
    {16'h0800, 16'h0401, 16'h0421},
    {16'h4000, 16'h00C1, 16'h0101},
    {16'hF000, 16'h0021, 16'h01C1},
    {16'h2800, 16'h0000, 16'h00A0}
  };

  // {aneg, speed100, full, expected control word}
  localparam logic [18:0] FRC_VEC [4] = '{
    {1'b0, 1'b0, 1'b1, 16'h0100},
    {1'b0, 1'b1, 1'b0, 16'h2000},
    {1'b1, 1'b0, 1'b1, 16'h2000},
    {1'b0, 1'b0, 1'b0, 16'h0000}
  };

  initial begin
    #(WD_CYC * 8);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = '0;
    stick = 1; rst_left = 0;
    clear_log();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mdio_req_valid && !timeout_flag && !check_due, "R1 reset outputs",
        {busy, mdio_req_valid, timeout_flag, check_due}, 0);
    chk(link_state == 2'd0, "R1 reset link_state", link_state, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table: advertisement merge on negotiation path
    for (int i = 0; i < 7; i++) begin
      regs[1] = ADV_VEC[i][47:32];
      regs[4] = ADV_VEC[i][31:16];
      stick = 1;
      clear_log();
      run_seq();
      chk(regs[4] == ADV_VEC[i][15:0] && wcount[4] == 1, "R2/R3 advert write", regs[4], ADV_VEC[i][15:0]);
      chk(ctrl_n == 2 && ctrl_log[0] == 16'h1000 && ctrl_log[1] == 16'h1200, "R4 ctrl writes",
          {ctrl_log[0], ctrl_log[1]}, 32'h10001200);
      chk(poll_n == 2 && gap_bad == 0, "R5 poll count/spacing", poll_n, 2);
      chk(link_state == 2'd1 && !timeout_flag, "R5 arbwait", {timeout_flag, link_state}, 1);
    end

    // R9 wait timer
    begin
      int n;
      n = 0;
      while (!check_due && n < WAITC + 10) begin @(negedge clk); n++; end
      chk(n == WAITC, "R9 wait length", n, WAITC);
      @(negedge clk);
      chk(!check_due, "R9 single pulse", check_due, 0);
    end

    // R6/R8 timeout fallback with vendor register clearing
    regs[5'h18] = 16'h0031;
    stick = 1000;
    phy_exempt = 1'b0;
    clear_log();
    run_seq();
    chk(poll_n == 63, "R6 poll limit", poll_n, 63);
    chk(gap_bad == 0, "R5 constant poll spacing", gap_bad, 0);
    chk(timeout_flag == 1'b1, "R6 timeout_flag", timeout_flag, 1);
    chk(ctrl_n == 3 && ctrl_log[2] == 16'h2000, "R6 fallback word", ctrl_log[2], 16'h2000);
    chk(regs[5'h18] == 16'h0011 && rcount[5'h18] == 1 && wcount[5'h18] == 1, "R8 vendor clear",
        regs[5'h18], 16'h0011);
    chk(link_state == 2'd2, "R8 ltrywait", link_state, 2);

    // R11 restart from wait clears timeout_flag; explicit forced mode
    force_req = 1'b1; force_aneg = 1'b0; force_speed100 = 1'b1; force_full = 1'b1;
    phy_exempt = 1'b1;
    clear_log();
    run_seq();
    chk(busy_seen && ls_at_busy, "R11 restart returns to idle", {busy_seen, ls_at_busy}, 3);
    chk(!timeout_flag && link_state == 2'd2, "R11 flag cleared", {timeout_flag, link_state}, 2);
    chk(ctrl_n == 1 && ctrl_log[0] == 16'h2100, "R7 forced 100 full", ctrl_log[0], 16'h2100);

    // R7/R8 forced words, exempt PHY
    for (int i = 0; i < 4; i++) begin
      force_aneg = FRC_VEC[i][18]; force_speed100 = FRC_VEC[i][17]; force_full = FRC_VEC[i][16];
      clear_log();
      run_seq();
      chk(ctrl_n == 1 && ctrl_log[0] == FRC_VEC[i][15:0], "R7 forced word", ctrl_log[0], FRC_VEC[i][15:0]);
      chk(wcount[4] == 0 && rcount[1] == 0 && rcount[5'h18] == 0 && wcount[5'h18] == 0,
          "R8 exempt no vendor access", rcount[5'h18] + wcount[5'h18] + wcount[4], 0);
    end

    // R10 start during busy is ignored
    force_req = 1'b0; phy_exempt = 1'b1; stick = 0;
    regs[1] = 16'h7800; regs[4] = 16'h0001;
    clear_log();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    chk(wcount[4] == 1 && rcount[1] == 1 && ctrl_n == 2 && poll_n == 1, "R10 start ignored",
        {wcount[4][7:0], rcount[1][7:0], ctrl_n[7:0], poll_n[7:0]}, 32'h01010201);

    // R11 start in the expiry cycle
    begin
      int n;
      n = 0;
      while (!check_due && n < WAITC + 10) begin @(negedge clk); n++; end
      chk(check_due, "R9 expiry seen", check_due, 1);
      force_req = 1'b1; force_aneg = 1'b1;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy && link_state == 2'd0, "R11 restart at expiry", {busy, link_state}, 4);
      while (busy) @(negedge clk);
      chk(link_state == 2'd2, "R11 restart completes", link_state, 2);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule